// File: doc/BRIEF.md
# Two-Channel Interleaved CIC Interpolator

This block raises the sample rate of two independent signed sample streams by a factor of four. It uses a cascaded integrator-comb structure. Both channels enter on one streaming port, time-multiplexed. A channel tag marks each sample, and a valid sample arrives at most every other clock, with the tags alternating. Because each channel then runs at a quarter of the clock rate, both channels can share one chain of comb stages. Each comb stage keeps a separate two-deep delay line per channel. The difference it forms for a channel therefore only ever uses that channel's own history.

After the comb chain, the stream is separated by tag. Each channel feeds its own rate expander, which emits the comb sample followed by three zeros. A four-stage integrator chain follows the expander. The integrators run at the full clock rate, so with sustained input each output port delivers a new sample on every clock. The internal datapath keeps full precision: 16 input bits plus 10 bits of growth, with two's-complement wraparound. The final result is scaled by 2^-10 and rounded half-to-even back to 16 bits. The overall DC gain is therefore one.

Top module: `cic_mc_interp`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) drives both `out_valid` bits low and clears every delay, counter and integrator register. The filter response after reset is exactly the response of an all-zero history.
- R2: Input protocol: `in_valid` is never high on two consecutive clocks. Consecutive valid samples carry alternating `in_chan` values. `in_chan` = 0 selects output index 0 and `in_chan` = 1 selects output index 1.
- R3: The two channels are isolated. A channel's output sequence depends only on the samples tagged with that channel, whatever the other channel carries.
- R4: Each accepted sample produces exactly four valid outputs on its channel, on four consecutive clocks. With the sustained cadence of R2, a channel's output is valid on every clock from its first output to its last.
- R5: The n-th output of a channel equals round(y[n] / 1024). Here y is the zero-stuffed input (each sample followed by three zeros) convolved with the 29 coefficients of (1 + z^-1 + ... + z^-7)^4.
- R6: For a constant input, the output equals that constant once the 28-output transient has passed.
- R7: Rounding is convergent. A fraction above one half rounds up, a fraction below rounds down, and an exact half goes to the even neighbour. For example, 512 maps to 0, 1536 to 2, -512 to 0 and -1536 to -2 for the first output of an isolated sample.
- R8: Full-scale inputs 32767 and -32768 pass through without any wrap error, settling to exactly 32767 and -32768.
- R9: When input stops, each output goes idle right after the fourth output of that channel's last sample, and stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_chan | input | 1 | Channel tag of the input sample |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 2 | Per-channel output strobe, bit c for channel c |
| out_data | output | 2x16 | Per-channel signed output sample, packed by channel |

## Verification
An isolated impulse on one channel with silence on the other shows the full 29-tap shape and the rounding of every phase. It also shows that nothing leaks across channels. A ramp on one channel against a square wave on the other separates correct per-channel delay indexing from any mixing of histories. Full-scale constants of opposite sign check the unity gain, the settling and the absence of wrap error. Small isolated samples placed exactly on rounding ties tell convergent rounding apart from truncation and from round-half-up. A run with a mid-stream reset and an explicit idle window afterwards shows that state is cleared and that output bursts end on time.

// File: rtl/cic_mc_pkg.sv
package cic_mc_pkg;

   // bit growth of an interpolating CIC: log2((R*M)^N / R)
   function automatic int cic_growth(input int n_stg, input int rate, input int dly);
      return n_stg * $clog2(rate * dly) - $clog2(rate);
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/cic_comb_stage.sv
module cic_comb_stage #(
   parameter int W    = 26,
   parameter int DLY  = 2,
   parameter int N_CH = 2,
   parameter int CH_W = 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                i_v,
   input  logic [CH_W-1:0]     i_ch,
   input  logic signed [W-1:0] i_d,
   output logic                o_v,
   output logic [CH_W-1:0]     o_ch,
   output logic signed [W-1:0] o_d
);

   // per-channel delay line, DLY deep
   logic signed [W-1:0] hist_q [N_CH][DLY];

   always_ff @(posedge clk) begin
      if (rst) begin
         o_v  <= 1'b0;
         o_ch <= '0;
         o_d  <= '0;
         for (int c = 0; c < N_CH; c++)
            for (int k = 0; k < DLY; k++)
               hist_q[c][k] <= '0;
      end else begin
         o_v <= i_v;
         if (i_v) begin
            o_ch <= i_ch;
            o_d  <= i_d - hist_q[i_ch][DLY-1];
            hist_q[i_ch][0] <= i_d;
            for (int k = DLY - 1; k > 0; k--)
               hist_q[i_ch][k] <= hist_q[i_ch][k-1];
         end
      end
   end

   // R2
   chan_range_chk: assert property (@(posedge clk) disable iff (rst)
      i_v |-> (int'(i_ch) < N_CH));

endmodule

// File: rtl/cic_round.sv
module cic_round #(
   parameter int IN_W  = 26,
   parameter int OUT_W = 16
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    i_v,
   input  logic signed [IN_W-1:0]  i_d,
   output logic                    o_v,
   output logic signed [OUT_W-1:0] o_d
);

   localparam int SHIFT = IN_W - OUT_W;

   if (SHIFT < 0) begin : g_bad_w
      $error("cic_round: output wider than input");
   end

   always_ff @(posedge clk) begin
      if (rst) o_v <= 1'b0;
      else     o_v <= i_v;
   end

   if (SHIFT == 0) begin : g_pass
      always_ff @(posedge clk) begin
         if (rst)      o_d <= '0;
         else if (i_v) o_d <= i_d;
      end
   end else begin : g_conv
      localparam logic [SHIFT-1:0] HALF = {1'b1, {(SHIFT-1){1'b0}}};
      logic [OUT_W-1:0] flr;
      logic [SHIFT-1:0] frac;
      logic             bump;

      assign flr  = i_d[IN_W-1:SHIFT];
      assign frac = i_d[SHIFT-1:0];
      assign bump = (frac > HALF) || ((frac == HALF) && flr[0]);

      always_ff @(posedge clk) begin
         if (rst)      o_d <= '0;
         else if (i_v) o_d <= flr + OUT_W'(bump);
      end

      // R7
      tie_even_chk: assert property (@(posedge clk) disable iff (rst)
         (i_v && (frac == HALF)) |=> (o_d[0] == 1'b0));
   end

endmodule

// File: rtl/cic_int_branch.sv
module cic_int_branch #(
   parameter int W     = 26,
   parameter int OUT_W = 16,
   parameter int N_STG = 4,
   parameter int RATE  = 4
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    smp_v,
   input  logic signed [W-1:0]     smp_d,
   output logic                    o_v,
   output logic signed [OUT_W-1:0] o_d
);

   localparam int CNT_W = (RATE > 2) ? $clog2(RATE) : 1;

   logic [CNT_W-1:0]    cnt_q;
   logic                step;
   logic signed [W-1:0] x;

   // zero-stuffing expander: sample, then RATE-1 zeros
   assign step = smp_v || (cnt_q != '0);
   assign x    = smp_v ? smp_d : '0;

   always_ff @(posedge clk) begin
      if (rst)               cnt_q <= '0;
      else if (smp_v)        cnt_q <= CNT_W'(RATE - 1);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   for (genvar k = 0; k < N_STG; k++) begin : g_int
      logic signed [W-1:0] acc_q;
      logic                v_q;
      logic signed [W-1:0] a_in;
      logic                v_in;

      if (k == 0) begin : g_head
         assign a_in = x;
         assign v_in = step;
      end else begin : g_tail
         assign a_in = g_int[k-1].acc_q;
         assign v_in = g_int[k-1].v_q;
      end

      always_ff @(posedge clk) begin
         if (rst) begin
            acc_q <= '0;
            v_q   <= 1'b0;
         end else begin
            v_q <= v_in;
            if (v_in) acc_q <= acc_q + a_in;
         end
      end
   end

   cic_round #(.IN_W(W), .OUT_W(OUT_W)) rnd_i (
      .clk (clk),
      .rst (rst),
      .i_v (g_int[N_STG-1].v_q),
      .i_d (g_int[N_STG-1].acc_q),
      .o_v (o_v),
      .o_d (o_d)
   );

   // R4
   burst_overlap_chk: assert property (@(posedge clk) disable iff (rst)
      smp_v |-> (cnt_q == '0));

   // R4
   zero_stuff_chk: assert property (@(posedge clk) disable iff (rst)
      smp_v |=> (step && (x == '0)));

endmodule

// File: rtl/cic_mc_interp.sv
module cic_mc_interp
   import cic_mc_pkg::*;
#(
   parameter int IN_W     = 16,
   parameter int OUT_W    = 16,
   parameter int N_STG    = 4,
   parameter int RATE     = 4,
   parameter int DIFF_DLY = 2,
   parameter int N_CH     = 2
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              in_valid,
   input  logic [((N_CH > 1) ? $clog2(N_CH) : 1)-1:0] in_chan,
   input  logic signed [IN_W-1:0]            in_data,
   output logic [N_CH-1:0]                   out_valid,
   output logic [N_CH-1:0][OUT_W-1:0]        out_data
);

   localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1;
   localparam int GROW  = cic_growth(N_STG, RATE, DIFF_DLY);
   localparam int ACC_W = IN_W + GROW;

   if (!is_pow2(RATE) || RATE < 2) begin : g_bad_rate
      $error("cic_mc_interp: RATE must be a power of two, at least 2");
   end
   if (!is_pow2(DIFF_DLY)) begin : g_bad_dly
      $error("cic_mc_interp: DIFF_DLY must be a power of two");
   end
   if (OUT_W > ACC_W || N_STG < 1) begin : g_bad_shape
      $error("cic_mc_interp: bad width or stage count");
   end

   logic                    cv [N_STG+1];
   logic [CH_W-1:0]         cc [N_STG+1];
   logic signed [ACC_W-1:0] cd [N_STG+1];

   assign cv[0] = in_valid;
   assign cc[0] = in_chan;
   assign cd[0] = ACC_W'(in_data);

   // shared comb chain at the interleaved low rate
   for (genvar s = 0; s < N_STG; s++) begin : g_comb
      cic_comb_stage #(.W(ACC_W), .DLY(DIFF_DLY), .N_CH(N_CH), .CH_W(CH_W)) comb_i (
         .clk  (clk),
         .rst  (rst),
         .i_v  (cv[s]),
         .i_ch (cc[s]),
         .i_d  (cd[s]),
         .o_v  (cv[s+1]),
         .o_ch (cc[s+1]),
         .o_d  (cd[s+1])
      );
   end

   // split by channel into private expander and integrators
   for (genvar c = 0; c < N_CH; c++) begin : g_chan
      logic                    br_v;
      logic signed [OUT_W-1:0] br_d;

      cic_int_branch #(.W(ACC_W), .OUT_W(OUT_W), .N_STG(N_STG), .RATE(RATE)) br_i (
         .clk   (clk),
         .rst   (rst),
         .smp_v (cv[N_STG] && (cc[N_STG] == CH_W'(c))),
         .smp_d (cd[N_STG]),
         .o_v   (br_v),
         .o_d   (br_d)
      );

      assign out_valid[c] = br_v;
      assign out_data[c]  = br_d;
   end

   // input protocol watch
   logic            seen_q;
   logic [CH_W-1:0] last_ch_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         seen_q    <= 1'b0;
         last_ch_q <= '0;
      end else if (in_valid) begin
         seen_q    <= 1'b1;
         last_ch_q <= in_chan;
      end
   end

   // R2
   input_spacing_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> !in_valid);

   // R2
   alt_chan_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && seen_q && (N_CH == 2)) |-> (in_chan != last_ch_q));

endmodule

// File: tb/cic_mc_interp_tb_top.sv
module cic_mc_interp_tb_top;

   // defaults: growth 10 bits, 29-tap response, 4 outputs per sample
   localparam int TAPS  = 29;
   localparam int SCALE = 1024;
   localparam int MAXN  = 64;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              in_valid = 1'b0;
   logic [0:0]        in_chan = 1'b0;
   logic signed [15:0] in_data = '0;
   logic [1:0]        out_valid;
   logic [1:0][15:0]  out_data;

   int total = 0;
   int bad   = 0;
   longint h [TAPS];
   int uin  [2][MAXN];
   int nin;
   int cap  [2][4*MAXN];
   int ncap [2];
   int fcyc [2];
   int lcyc [2];
   int cyc = 0;

   cic_mc_interp dut_i (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_chan   (in_chan),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   always #10 clk = ~clk;

   always @(negedge clk) begin
      cyc++;
      if (!rst) begin
         for (int c = 0; c < 2; c++) begin
            if (out_valid[c]) begin
               if (ncap[c] == 0) fcyc[c] = cyc;
               lcyc[c] = cyc;
               if (ncap[c] < 4*MAXN) cap[c][ncap[c]] = int'($signed(out_data[c]));
               ncap[c]++;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int rnd_conv(input longint s);
      longint q = s >>> 10;
      longint f = s - q * SCALE;
      if (f > SCALE/2 || (f == SCALE/2 && (q % 2) != 0)) q++;
      return int'(q);
   endfunction

   function automatic int expv(input int c, input int n);
      longint s = 0;
      for (int k = 0; k < TAPS; k++) begin
         int m = n - k;
         if (m >= 0 && (m % 4) == 0 && (m / 4) < nin)
            s += h[k] * longint'(uin[c][m/4]);
      end
      return rnd_conv(s);
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      ncap[0] = 0; ncap[1] = 0;
   endtask

   task automatic drive_all(input int drain);
      for (int i = 0; i < nin; i++) begin
         for (int ch = 0; ch < 2; ch++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_chan  = 1'(ch);
            in_data  = 16'(uin[ch][i]);
            @(negedge clk);
            in_valid = 1'b0;
         end
      end
      repeat (drain) @(negedge clk);
   endtask

   task automatic compare_all(input string tag);
      for (int c = 0; c < 2; c++) begin
         chk(ncap[c] == 4*nin, {tag, " R4 count"}, ncap[c], 4*nin);
         chk(lcyc[c] - fcyc[c] + 1 == ncap[c], {tag, " R4 contiguous"},
             lcyc[c] - fcyc[c] + 1, ncap[c]);
         for (int n = 0; n < 4*nin && n < ncap[c]; n++)
            chk(cap[c][n] == expv(c, n), $sformatf("%s R5 ch%0d n%0d", tag, c, n),
                cap[c][n], expv(c, n));
      end
   endtask

   task automatic clear_inputs();
      for (int c = 0; c < 2; c++)
         for (int i = 0; i < MAXN; i++) uin[c][i] = 0;
   endtask

   task automatic t_reset();
      do_reset();
      repeat (4) begin
         @(negedge clk);
         chk(out_valid == 2'b00, "R1 idle after reset", out_valid, 0);
      end
   endtask

   task automatic t_midreset();
      clear_inputs();
      nin = 6;
      for (int i = 0; i < nin; i++) begin uin[0][i] = 32767; uin[1][i] = -20000; end
      drive_all(3);
      do_reset();
      @(negedge clk);
      chk(out_valid == 2'b00, "R1 valid cleared by reset", out_valid, 0);
      clear_inputs();
      nin = 8;
      uin[0][0] = 777; uin[1][0] = -333;
      drive_all(20);
      compare_all("R1 clean history");
   endtask

   task automatic t_impulse();
      do_reset();
      clear_inputs();
      nin = 10;
      uin[0][0] = 1000;
      drive_all(20);
      compare_all("impulse");
      for (int n = 0; n < ncap[1] && n < 4*MAXN; n++)
         chk(cap[1][n] == 0, "R3 silent channel", cap[1][n], 0);
   endtask

   task automatic t_mixed();
      do_reset();
      clear_inputs();
      nin = 16;
      for (int i = 0; i < nin; i++) begin
         uin[0][i] = 300*i - 2000;
         uin[1][i] = (i % 2) ? 5000 : -7000;
      end
      drive_all(20);
      compare_all("R3 ramp vs square");
   endtask

   task automatic t_dc();
      do_reset();
      clear_inputs();
      nin = 12;
      for (int i = 0; i < nin; i++) begin uin[0][i] = 32767; uin[1][i] = -32768; end
      drive_all(20);
      compare_all("R8 full scale");
      for (int n = 28; n < 4*nin; n++) begin
         chk(cap[0][n] == 32767, "R6 R8 settled positive", cap[0][n], 32767);
         chk(cap[1][n] == -32768, "R6 R8 settled negative", cap[1][n], -32768);
      end
   endtask

   task automatic t_ties(input int a, input int b, input int ea, input int eb);
      do_reset();
      clear_inputs();
      nin = 3;
      uin[0][0] = a; uin[1][0] = b;
      drive_all(20);
      chk(cap[0][0] == ea, "R7 tie ch0", cap[0][0], ea);
      chk(cap[1][0] == eb, "R7 tie ch1", cap[1][0], eb);
      compare_all("R7 ties");
   endtask

   task automatic t_stop();
      int late = 0;
      do_reset();
      clear_inputs();
      nin = 5;
      for (int i = 0; i < nin; i++) begin uin[0][i] = 4000; uin[1][i] = 1234; end
      drive_all(15);
      compare_all("R9 burst");
      repeat (30) begin
         @(negedge clk);
         if (out_valid != 2'b00) late++;
      end
      chk(late == 0, "R9 idle after last burst", late, 0);
   endtask

   initial begin
      longint t [TAPS];
      int len = 1;
      for (int k = 0; k < TAPS; k++) h[k] = 0;
      h[0] = 1;
      repeat (4) begin
         for (int k = 0; k < TAPS; k++) t[k] = 0;
         for (int k = 0; k < len; k++)
            for (int j = 0; j < 8; j++) t[k+j] += h[k];
         len += 7;
         for (int k = 0; k < TAPS; k++) h[k] = t[k];
      end
      ncap[0] = 0; ncap[1] = 0;
      t_reset();
      t_impulse();
      t_mixed();
      t_dc();
      t_ties(512, 1536, 0, 2);
      t_ties(-512, -1536, 0, -2);
      t_stop();
      t_midreset();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      total++;
      bad++;
      $display("FAIL watchdog R4 actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule